// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

A 4,608-bit simple dual-port memory with one write port and one read port on a shared clock. Each port has its own enable and its own 3-bit shape select, so the two ports may see the same storage at different word widths at the same time. Physically the store is 256 rows of 18 bits. Each row holds two 9-bit halves, and each half is one byte of data plus one parity bit.

The 18-bit and 9-bit shapes reach every bit, the parity bits included. The 4-, 2- and 1-bit shapes see only the 4,096 data bits, as one linear bit stream. In that stream, narrow word n at width w covers stream bits n*w to n*w+w-1. Stream bit L lives in row L/16, data bit L%16. Within a row, data bits 0..7 sit at physical bits 0..7 and data bits 8..15 sit at physical bits 9..16. Physical bits 8 and 17 are the parity bits.

A typical use writes through one shape and reads through another. One example is loading nibbles and then streaming them out one bit at a time, low address first.

Top module: `mwdp_ram`

## Requirements
- R1: A synchronous active-high reset forces `rd_data` to zero after the clock edge where `rst` is high. Reset does not alter the stored contents.
- R2: The shape code selects the word width as follows:
  - 4 selects 256 words of 18 bits. `addr[7:0]` picks the row and the word is the whole row.
  - 3 selects 512 words of 9 bits. `addr[8:1]` picks the row. `addr[0]` = 0 selects physical bits 8:0 and `addr[0]` = 1 selects physical bits 17:9.
- R3: A 9-bit word written at address a reads back through the 18-bit shape at row a>>1, in the half chosen by a[0]. Its bit 8 is the parity bit of that half.
- R4: Codes 2, 1 and 0 select 4-, 2- and 1-bit words (1k, 2k and 4k deep). These words map little-endian onto the data-bit stream, with stream bit L at row L/16, data bit L%16. Writes in these shapes never change physical bits 8 or 17.
- R5: Data written through a 4-bit or 2-bit port reads back correctly as a stream of single bits through the 1-bit port.
- R6: Read data for an access sampled with `rd_en` high appears on `rd_data` one clock later.
- R7: While `rd_en` is low, `rd_data` holds its last value, even when writes change the addressed location.
- R8: While `wr_en` is low, the stored contents do not change.
- R9: A read and a write to the same location in the same cycle return the old data. The new data is visible to the next read. This also holds when the two ports use different widths.
- R10: Output bits above the read word width are zero.
- R11: The reserved shape codes 5, 6 and 7 behave as the 1-bit shape.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset of the read output |
| wr_en | input | 1 | Write enable |
| wr_mode | input | 3 | Write port shape code |
| wr_addr | input | 12 | Write word address in the write shape |
| wr_data | input | 18 | Write data, low bits used in narrow shapes |
| rd_en | input | 1 | Read enable |
| rd_mode | input | 3 | Read port shape code |
| rd_addr | input | 12 | Read word address in the read shape |
| rd_data | output | 18 | Read data, zero-extended to 18 bits |

## Verification
The hardest case to reach from the ports is a read and a write that overlap on one physical row in different shapes in the same cycle. An example is a 1-bit write landing inside the 18-bit row being read. The result must show the old row and must leave the parity bits untouched. The stimulus first fills rows through the 18-bit shape with the parity bits set. It then issues narrow writes to the same row, in the same cycle as wide and narrow reads of that row, and reads the row back through the 18-bit shape to expose every physical bit. A second pass streams nibble-written data out bit by bit, which walks every lane boundary, including the jump over the parity bit.

// File: rtl/mwdp_pkg.sv
package mwdp_pkg;
  localparam int ROW_W  = 18;
  localparam int DATA_W = 16;
  localparam int LANE_W = 4;

  typedef enum logic [2:0] {
    SHP_X1  = 3'd0,
    SHP_X2  = 3'd1,
    SHP_X4  = 3'd2,
    SHP_X9  = 3'd3,
    SHP_X18 = 3'd4
  } shape_e;

  // reserved codes fall back to the single-bit shape
  function automatic shape_e decode_shape(input logic [2:0] code);
    case (code)
      3'd1:    return SHP_X2;
      3'd2:    return SHP_X4;
      3'd3:    return SHP_X9;
      3'd4:    return SHP_X18;
      default: return SHP_X1;
    endcase
  endfunction

  // spread a 16-bit data-lane vector over the 18-bit row, skipping parity
  function automatic logic [ROW_W-1:0] spread_data(input logic [DATA_W-1:0] d);
    return {1'b0, d[15:8], 1'b0, d[7:0]};
  endfunction

  function automatic logic [DATA_W-1:0] gather_data(input logic [ROW_W-1:0] r);
    return {r[16:9], r[7:0]};
  endfunction
endpackage

// File: rtl/mwdp_addr_split.sv
module mwdp_addr_split
  import mwdp_pkg::*;
#(
  parameter int ROWS = 256,
  localparam int RA = $clog2(ROWS),
  localparam int AW = RA + LANE_W
) (
  input  shape_e            shape,
  input  logic [AW-1:0]     addr,
  output logic [RA-1:0]     row,
  output logic [LANE_W-1:0] lane
);
  always_comb begin
    case (shape)
      SHP_X18: begin
        row  = addr[RA-1:0];
        lane = '0;
      end
      SHP_X9: begin
        row  = addr[RA:1];
        lane = {3'b000, addr[0]};
      end
      SHP_X4: begin
        row  = addr[RA+1:2];
        lane = {2'b00, addr[1:0]};
      end
      SHP_X2: begin
        row  = addr[RA+2:3];
        lane = {1'b0, addr[2:0]};
      end
      default: begin
        row  = addr[RA+3:4];
        lane = addr[3:0];
      end
    endcase
  end
endmodule

// File: rtl/mwdp_wr_lane.sv
module mwdp_wr_lane
  import mwdp_pkg::*;
(
  input  shape_e            shape,
  input  logic [LANE_W-1:0] lane,
  input  logic [ROW_W-1:0]  wdata,
  output logic [ROW_W-1:0]  mask,
  output logic [ROW_W-1:0]  bits
);
  logic [DATA_W-1:0] dmask;
  logic [DATA_W-1:0] dbits;

  always_comb begin
    dmask = '0;
    dbits = '0;
    mask  = '0;
    bits  = '0;
    case (shape)
      SHP_X18: begin
        mask = '1;
        bits = wdata;
      end
      SHP_X9: begin
        mask = lane[0] ? 18'h3FE00 : 18'h001FF;
        bits = {wdata[8:0], wdata[8:0]};
      end
      SHP_X4: begin
        dmask = 16'h000F << {lane[1:0], 2'b00};
        dbits = {4{wdata[3:0]}};
        mask  = spread_data(dmask);
        bits  = spread_data(dbits);
      end
      SHP_X2: begin
        dmask = 16'h0003 << {lane[2:0], 1'b0};
        dbits = {8{wdata[1:0]}};
        mask  = spread_data(dmask);
        bits  = spread_data(dbits);
      end
      default: begin
        dmask = 16'h0001 << lane;
        dbits = {16{wdata[0]}};
        mask  = spread_data(dmask);
        bits  = spread_data(dbits);
      end
    endcase
  end
endmodule

// File: rtl/mwdp_array.sv
module mwdp_array
  import mwdp_pkg::*;
#(
  parameter int ROWS = 256,
  localparam int RA = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [RA-1:0]    wrow,
  input  logic [ROW_W-1:0] wmask,
  input  logic [ROW_W-1:0] wbits,
  input  logic             re,
  input  logic [RA-1:0]    rrow,
  output logic [ROW_W-1:0] q
);
  logic [ROW_W-1:0] mem [ROWS];

  // bit-masked write port
  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < ROW_W; b++) begin
        if (wmask[b]) mem[wrow][b] <= wbits[b];
      end
    end
  end

  // registered read port, old data on collision, resettable output latch
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= mem[rrow];
  end
endmodule

// File: rtl/mwdp_rd_sel.sv
module mwdp_rd_sel
  import mwdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  shape_e            shape,
  input  logic [LANE_W-1:0] lane,
  input  logic [ROW_W-1:0]  q,
  output logic [ROW_W-1:0]  dout
);
  shape_e            shape_q;
  logic [LANE_W-1:0] lane_q;
  logic [DATA_W-1:0] dlane;

  always_ff @(posedge clk) begin
    if (rst) begin
      shape_q <= SHP_X18;
      lane_q  <= '0;
    end else if (en) begin
      shape_q <= shape;
      lane_q  <= lane;
    end
  end

  always_comb begin
    dlane = gather_data(q);
    dout  = '0;
    case (shape_q)
      SHP_X18: dout = q;
      SHP_X9:  dout = {9'b0, (lane_q[0] ? q[17:9] : q[8:0])};
      SHP_X4:  dout = {14'b0, dlane[{lane_q[1:0], 2'b00} +: 4]};
      SHP_X2:  dout = {16'b0, dlane[{lane_q[2:0], 1'b0} +: 2]};
      default: dout = {17'b0, dlane[lane_q]};
    endcase
  end
endmodule

// File: rtl/mwdp_ram.sv
module mwdp_ram
  import mwdp_pkg::*;
#(
  parameter int ROWS = 256,
  localparam int RA = $clog2(ROWS),
  localparam int AW = RA + LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_mode,
  input  logic [AW-1:0]    wr_addr,
  input  logic [ROW_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [2:0]       rd_mode,
  input  logic [AW-1:0]    rd_addr,
  output logic [ROW_W-1:0] rd_data
);
  shape_e            wshape, rshape;
  logic [RA-1:0]     wrow, rrow;
  logic [LANE_W-1:0] wlane, rlane;
  logic [ROW_W-1:0]  wmask, wbits, rq;

  assign wshape = decode_shape(wr_mode);
  assign rshape = decode_shape(rd_mode);

  mwdp_addr_split #(.ROWS(ROWS)) wsplit_i (
    .shape(wshape), .addr(wr_addr), .row(wrow), .lane(wlane)
  );

  mwdp_addr_split #(.ROWS(ROWS)) rsplit_i (
    .shape(rshape), .addr(rd_addr), .row(rrow), .lane(rlane)
  );

  mwdp_wr_lane wlane_i (
    .shape(wshape), .lane(wlane), .wdata(wr_data), .mask(wmask), .bits(wbits)
  );

  mwdp_array #(.ROWS(ROWS)) array_i (
    .clk(clk), .rst(rst),
    .we(wr_en), .wrow(wrow), .wmask(wmask), .wbits(wbits),
    .re(rd_en), .rrow(rrow), .q(rq)
  );

  mwdp_rd_sel rsel_i (
    .clk(clk), .rst(rst), .en(rd_en), .shape(rshape), .lane(rlane),
    .q(rq), .dout(rd_data)
  );
endmodule

// File: rtl/mwdp_ram_chk.sv
module mwdp_ram_chk
  import mwdp_pkg::*;
#(
  parameter int ROWS = 256,
  localparam int RA = $clog2(ROWS),
  localparam int AW = RA + LANE_W
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [2:0]       wr_mode,
  input logic [AW-1:0]    wr_addr,
  input logic [ROW_W-1:0] wr_data,
  input logic             rd_en,
  input logic [2:0]       rd_mode,
  input logic [AW-1:0]    rd_addr,
  input logic [ROW_W-1:0] rd_data
);
  assert_reset_clears_output_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rd_data == '0);

  assert_idle_read_holds_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  assert_x1_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_mode == 3'd0) |=> rd_data[17:1] == '0);

  assert_x4_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_mode == 3'd2) |=> rd_data[17:4] == '0);

  assert_x9_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_mode == 3'd3) |=> rd_data[17:9] == '0);

  assert_reserved_as_x1_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_mode >= 3'd5) |=> rd_data[17:1] == '0);
endmodule

bind mwdp_ram mwdp_ram_chk #(.ROWS(ROWS)) chk_i (.*);

// File: tb/mwdp_ram_tb_top.sv
`timescale 1ns/1ps
module mwdp_ram_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_mode = 3'd4;
  logic [11:0] wr_addr = '0;
  logic [17:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_mode = 3'd4;
  logic [11:0] rd_addr = '0;
  logic [17:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [17:0] exp_q[$];
  string       tag_q[$];
  logic [17:0] mrow [256];

  always #10 clk = ~clk;

  mwdp_ram dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mode(wr_mode), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_mode(rd_mode), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  function automatic int width_of(input logic [2:0] code);
    case (code)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 9;
      3'd4: return 18;
      default: return 1;
    endcase
  endfunction

  function automatic int phys_bit(input int k);
    return (k < 8) ? k : k + 1;
  endfunction

  function automatic logic [17:0] model_read(input logic [2:0] code, input logic [11:0] a);
    int w = width_of(code);
    logic [17:0] r = '0;
    if (w == 18) r = mrow[a[7:0]];
    else if (w == 9) r = a[0] ? {9'b0, mrow[a[8:1]][17:9]} : {9'b0, mrow[a[8:1]][8:0]};
    else begin
      for (int i = 0; i < w; i++) begin
        int lin = int'(a) * w + i;
        r[i] = mrow[(lin >> 4) & 255][phys_bit(lin & 15)];
      end
    end
    return r;
  endfunction

  task automatic model_write(input logic [2:0] code, input logic [11:0] a, input logic [17:0] d);
    int w = width_of(code);
    if (w == 18) mrow[a[7:0]] = d;
    else if (w == 9) begin
      if (a[0]) mrow[a[8:1]][17:9] = d[8:0];
      else      mrow[a[8:1]][8:0]  = d[8:0];
    end else begin
      for (int i = 0; i < w; i++) begin
        int lin = int'(a) * w + i;
        mrow[(lin >> 4) & 255][phys_bit(lin & 15)] = d[i];
      end
    end
  endtask

  task automatic check(input logic [17:0] got, input logic [17:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %05h expected %05h", tag, got, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected read result computed before the write lands
  task automatic op(input bit we, input logic [2:0] wm, input logic [11:0] wa,
                    input logic [17:0] wd, input bit re, input logic [2:0] rm,
                    input logic [11:0] ra, input string tag);
    @(negedge clk);
    wr_en = we; wr_mode = wm; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_mode = rm; rd_addr = ra;
    if (re) begin
      exp_q.push_back(model_read(rm, ra));
      tag_q.push_back(tag);
    end
    if (we) model_write(wm, wa, wd);
  endtask

  task automatic wr(input logic [2:0] m, input logic [11:0] a, input logic [17:0] d);
    op(1'b1, m, a, d, 1'b0, 3'd4, 12'd0, "");
  endtask

  task automatic rd(input logic [2:0] m, input logic [11:0] a, input string tag);
    op(1'b0, 3'd4, 12'd0, 18'd0, 1'b1, m, a, tag);
  endtask

  task automatic idle();
    op(1'b0, 3'd4, 12'd0, 18'd0, 1'b0, 3'd4, 12'd0, "");
  endtask

  // monitor: compares each read result one clock after its request was sampled (R6)
  initial begin
    forever begin
      @(posedge clk);
      #4;
      if (rd_en && !rst) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6: unexpected read result %05h expected none", rd_data);
        end else begin
          check(rd_data, exp_q.pop_front(), tag_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [17:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #4;
    check(rd_data, 18'd0, "R1 reset output");

    // R2 / R6: full-width rows, back-to-back reads
    wr(3'd4, 12'd0,   18'h2A5A5);
    wr(3'd4, 12'd255, 18'h3FFFF);
    wr(3'd4, 12'd1,   18'h15555);
    rd(3'd4, 12'd0,   "R2 x18 row0");
    rd(3'd4, 12'd255, "R2 x18 row255");
    rd(3'd4, 12'd1,   "R6 x18 back-to-back row1");
    rd(3'd3, 12'd1,   "R2 x9 upper half of row0");

    // R3: 9-bit words into rows 10,11
    wr(3'd3, 12'd20, 18'h001A5);
    wr(3'd3, 12'd21, 18'h000FF);
    wr(3'd3, 12'd22, 18'h00100);
    wr(3'd3, 12'd23, 18'h00055);
    for (int i = 20; i < 24; i++) rd(3'd3, 12'(i), "R3 x9 readback");
    rd(3'd4, 12'd10, "R3 x9 halves in row10");
    rd(3'd4, 12'd11, "R3 x9 halves in row11");

    // R4 / R5: nibbles over rows 40,41 with parity set, then serial read
    wr(3'd4, 12'd40, 18'h3FFFF);
    wr(3'd4, 12'd41, 18'h3FFFF);
    for (int i = 0; i < 8; i++) wr(3'd2, 12'(160 + i), 18'(i * 3 + 1));
    for (int i = 0; i < 32; i++) rd(3'd0, 12'(640 + i), "R5 x4 write x1 read");
    rd(3'd4, 12'd40, "R4 parity kept row40");
    rd(3'd4, 12'd41, "R4 parity kept row41");
    for (int i = 0; i < 8; i++) rd(3'd1, 12'(320 + i), "R4 x2 view of nibbles");
    rd(3'd3, 12'd81, "R4 x9 view of nibbles");

    // R5: 2-bit writes read serially
    wr(3'd4, 12'd50, 18'h20100);
    for (int i = 0; i < 8; i++) wr(3'd1, 12'(400 + i), 18'(i));
    for (int i = 0; i < 16; i++) rd(3'd0, 12'(800 + i), "R5 x2 write x1 read");
    for (int i = 0; i < 4; i++) rd(3'd2, 12'(200 + i), "R4 x4 view of x2 data");

    // R4: single-bit writes keep parity
    wr(3'd4, 12'd60, 18'h20100);
    for (int i = 0; i < 16; i++) wr(3'd0, 12'(960 + i), 18'(i % 3 == 0));
    rd(3'd4, 12'd60, "R4 x1 writes keep parity");

    // R8: write enable low
    wr(3'd4, 12'd70, 18'h12345);
    op(1'b0, 3'd4, 12'd70, 18'h0BEEF, 1'b0, 3'd4, 12'd0, "");
    op(1'b0, 3'd0, 12'd1120, 18'h00001, 1'b0, 3'd4, 12'd0, "");
    rd(3'd4, 12'd70, "R8 disabled write ignored");

    // R9: collisions, same and mixed widths
    wr(3'd4, 12'd80, 18'h0AAAA);
    op(1'b1, 3'd4, 12'd80, 18'h15555, 1'b1, 3'd4, 12'd80, "R9 same width old data");
    rd(3'd4, 12'd80, "R9 new data next read");
    op(1'b1, 3'd0, 12'd1280, 18'h00000, 1'b1, 3'd4, 12'd80, "R9 x1 write x18 read old");
    op(1'b1, 3'd4, 12'd80, 18'h3FFFF, 1'b1, 3'd0, 12'd1281, "R9 x18 write x1 read old");
    rd(3'd4, 12'd80, "R9 row after mixed collisions");

    // R7: hold while read disabled
    rd(3'd4, 12'd0, "R7 read before hold");
    held = 18'h2A5A5;
    op(1'b1, 3'd4, 12'd0, 18'h00007, 1'b0, 3'd4, 12'd0, "");
    @(posedge clk); #4;
    check(rd_data, held, "R7 hold during write");
    idle();
    @(posedge clk); #4;
    check(rd_data, held, "R7 hold second idle cycle");

    // R11: reserved codes act as 1-bit
    wr(3'd4, 12'd90, 18'h00000);
    wr(3'd5, 12'd1443, 18'h3FFFF);
    rd(3'd7, 12'd1443, "R11 code7 read");
    rd(3'd0, 12'd1443, "R11 code0 read");
    rd(3'd6, 12'd1442, "R11 neighbour untouched");
    rd(3'd4, 12'd90, "R11 row view");

    // R1: mid-run reset clears output, keeps contents
    rd(3'd4, 12'd255, "R1 prime output");
    @(negedge clk); rst = 1'b1; rd_en = 1'b0; wr_en = 1'b0;
    @(posedge clk); #4;
    check(rd_data, 18'd0, "R1 mid-run reset output");
    @(negedge clk); rst = 1'b0;
    rd(3'd4, 12'd255, "R1 contents kept after reset");
    idle();
    idle();
    @(posedge clk); #4;
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R6: got %0d pending reads expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule